// File: doc/BRIEF.md
# Flash Timing Tick Divider

This block derives the slow timing reference used to pace flash and EEPROM program and erase steps from the module's input oscillator clock. Software writes one 8-bit configuration register. Bits 5:0 hold a divider value. Bit 6 optionally inserts a fixed divide-by-8 stage ahead of the divider. Bit 7 is a read-only marker that shows whether the register has been written since reset. Software should choose a setting that brings the tick rate into the 150 kHz to 200 kHz window.

The divided output is a one-cycle enable pulse in the input clock domain, not a generated clock. Downstream timers count these pulses. The pulse is held off until the register has been written at least once, so no timed operation can start on an unconfigured divider. Each write restarts both counting stages from zero, which makes the new ratio apply from the cycle after the write.

Top module: `flash_tick_divider`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00, `cfg_done` is 0 and `tick` is 0.
- R2: Any write sets the written flag (bit 7, mirrored on `cfg_done`). The flag stays set until the next reset.
- R3: The value written to bit 7 has no effect. The flag reads 1 after a write whose bit 7 is 0, and also after a write whose bit 7 is 1.
- R4: Bits 6:0 read back exactly the value last written to bits 6:0.
- R5: While the flag is 0, `tick` stays 0.
- R6: With bit 6 = 0 and divider value D, `tick` pulses once every D+1 input cycles. D = 0 gives a pulse on every cycle.
- R7: With bit 6 = 1, `tick` pulses once every 8*(D+1) cycles. The maximum ratio of 512 is reached with D = 63.
- R8: A write restarts counting. With ratio N, the first pulse comes in the Nth cycle after the write edge, counting the cycle that directly follows the edge as the first.
- R9: For any ratio N > 1, `tick` is high for exactly one cycle in every N cycles and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data; bit 7 is ignored |
| rd_data | output | 8 | Current register value {flag, prescale enable, divider} |
| tick | output | 1 | One-cycle timing enable pulse |
| cfg_done | output | 1 | Written flag |

## Verification
The read port is combinational from the register, so the written value and the flag are both due in the cycle after the write edge. The bench compares them at the falling edge that follows that write. The tick is due N cycles after a write, where N is the programmed ratio. A behavioural model restarts a cycle count at each write and expects a pulse whenever that count reaches N-1 modulo N. The bench compares the model with the design on every falling edge, and it also measures the distance to the first pulse and the number of pulses over long windows, including the 512 ratio.

// File: rtl/ftd_pkg.sv
// Package: shared constants and types for the flash timing tick divider.
// Assumes the register layout {flag, prescale enable, divider} with the flag on top.
package ftd_pkg;
    // Default width of the programmable divider field.
    localparam int FTD_DIV_W    = 6;
    // Default log2 of the fixed prescale factor (3 -> divide by 8).
    localparam int FTD_PRE_LOG2 = 3;

    // Prescaler selection decoded from the prescale enable bit.
    typedef enum logic {
        PRE_BYPASS = 1'b0,
        PRE_FIXED  = 1'b1
    } ftd_pre_mode_e;
endpackage

// File: rtl/ftd_cfg_reg.sv
// Module: configuration register with a sticky "written" flag.
// Bits below the top bit are plain read/write storage. The top bit is set by any
// write and is cleared only by reset. A single-cycle write strobe is assumed.
module ftd_cfg_reg #(
    parameter int DIV_W = 6,
    localparam int REG_W = DIV_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic                 loaded,
    output ftd_pkg::ftd_pre_mode_e pre_mode,
    output logic [DIV_W-1:0]     div_val,
    output logic [REG_W-1:0]     rd_data
);
    logic [REG_W-2:0] cfg_q;
    logic             flag_q;

    // Store the writable bits; the top data bit is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data[REG_W-2:0];
        end
    end

    // Sticky written flag: set on any write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wr_en) begin
            flag_q <= 1'b1;
        end
    end

    // Decode fields for the counting stages.
    always_comb begin
        loaded   = flag_q;
        pre_mode = ftd_pkg::ftd_pre_mode_e'(cfg_q[REG_W-2]);
        div_val  = cfg_q[DIV_W-1:0];
        rd_data  = {flag_q, cfg_q};
    end
endmodule

// File: rtl/ftd_prescaler.sv
// Module: optional fixed power-of-two prescaler.
// Emits a step strobe that is either every running cycle (bypass) or one in
// 2**PRE_LOG2 cycles. The counter is cleared by restart and held while idle.
// PRE_LOG2 = 0 builds a pure pass-through.
module ftd_prescaler #(
    parameter int PRE_LOG2 = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   restart,
    input  ftd_pkg::ftd_pre_mode_e pre_mode,
    output logic                   step
);
    generate
        if (PRE_LOG2 > 0) begin : g_pre
            logic [PRE_LOG2-1:0] pcnt_q;
            logic                use_pre;

            // Select whether the fixed stage is active.
            always_comb use_pre = (pre_mode == ftd_pkg::PRE_FIXED);

            // Count input cycles while the fixed stage is active; clear otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pcnt_q <= '0;
                end else if (restart || !run || !use_pre) begin
                    pcnt_q <= '0;
                end else begin
                    pcnt_q <= pcnt_q + 1'b1;
                end
            end

            // Strobe on the last count of the fixed stage, or every cycle in bypass.
            always_comb step = run && (!use_pre || (pcnt_q == '1));
        end else begin : g_nopre
            logic unused_in;
            // No fixed stage: every running cycle is a step.
            always_comb begin
                step      = run;
                unused_in = clk ^ rst_n ^ restart ^ pre_mode;
            end
        end
    endgenerate
endmodule

// File: rtl/ftd_divider.sv
// Module: programmable modulo-(limit+1) divider driven by a step strobe.
// The pulse goes out in the step in which the counter sits at the limit.
// A restart returns the counter to zero on the same edge.
module ftd_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [DIV_W-1:0] limit,
    output logic             pulse
);
    logic [DIV_W-1:0] dcnt_q;
    logic             at_limit;

    // Compare the count with the programmed limit.
    always_comb at_limit = (dcnt_q == limit);

    // Advance on each step and wrap after the limit; restart clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt_q <= '0;
        end else if (restart) begin
            dcnt_q <= '0;
        end else if (step) begin
            dcnt_q <= at_limit ? '0 : dcnt_q + 1'b1;
        end
    end

    // One pulse per wrap.
    always_comb pulse = step && at_limit;
endmodule

// File: rtl/flash_tick_divider.sv
// Module: top of the flash timing tick divider.
// Register write port, prescaler and divider chain, one-cycle tick output.
// Counting runs only once the register has been written. Each write restarts both stages.
module flash_tick_divider #(
    parameter int DIV_W    = ftd_pkg::FTD_DIV_W,
    parameter int PRE_LOG2 = ftd_pkg::FTD_PRE_LOG2,
    localparam int REG_W   = DIV_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             tick,
    output logic             cfg_done
);
    logic                   loaded;
    ftd_pkg::ftd_pre_mode_e pre_mode;
    logic [DIV_W-1:0]       div_val;
    logic                   pre_step;

    ftd_cfg_reg #(.DIV_W(DIV_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .loaded   (loaded),
        .pre_mode (pre_mode),
        .div_val  (div_val),
        .rd_data  (rd_data)
    );

    ftd_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (loaded),
        .restart  (wr_en),
        .pre_mode (pre_mode),
        .step     (pre_step)
    );

    ftd_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_en),
        .step     (pre_step),
        .limit    (div_val),
        .pulse    (tick)
    );

    // Mirror the written flag on its own pin.
    always_comb cfg_done = loaded;
endmodule

// File: rtl/ftd_checker.sv
// Module: property checker for flash_tick_divider, attached by bind.
// It watches only the top-level ports.
module ftd_checker #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             tick,
    input logic             cfg_done
);
    AST_WRITE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_done);                                        // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);                                     // R2
    AST_LOW_BITS_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[REG_W-2:0] == $past(wr_data[REG_W-2:0])); // R4
    AST_QUIET_UNTIL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !tick);                                       // R5
    AST_RESTART_NO_EARLY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[REG_W-2:0] != '0) |=> !tick);             // R8
    AST_SINGLE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && rd_data[REG_W-2:0] != '0) |=> !tick);    // R9
endmodule

bind flash_tick_divider ftd_checker #(.REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .tick     (tick),
    .cfg_done (cfg_done)
);

// File: tb/sim_flash_tick_divider.sv
module sim_flash_tick_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick;
    logic       cfg_done;

    int errors = 0;
    int checks = 0;
    int tick_count = 0;
    bit finished = 0;

    // behavioural model state
    bit m_flag = 0;
    int m_cfg = 0;
    int m_since = 0;
    bit m_tick;

    always #5 clk = ~clk;

    flash_tick_divider u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .cfg_done(cfg_done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int ratio();
        return (((m_cfg >> 6) & 1) ? 8 : 1) * ((m_cfg & 63) + 1);
    endfunction

    // one clock: update the model at the rising edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_flag = 0; m_cfg = 0; m_since = 0;
        end else if (wr_en) begin
            m_flag = 1; m_cfg = wr_data & 8'h7F; m_since = 0;
        end else if (m_flag) begin
            m_since++;
        end
        @(negedge clk);
        m_tick = m_flag && ((m_since % ratio()) == ratio() - 1);
        chk(rd_data == {m_flag, 7'(m_cfg)}, "R4", "rd_data", rd_data, {m_flag, 7'(m_cfg)});
        chk(cfg_done == m_flag, "R2", "cfg_done", cfg_done, m_flag);
        chk(tick == m_tick, !m_flag ? "R5" : (((m_cfg >> 6) & 1) ? "R7" : "R6"),
            "tick", tick, m_tick);
        if (tick) tick_count++;
    endtask

    task automatic write_reg(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // cycles from a write edge to the first pulse (write cycle counts as 1)
    task automatic first_tick_after(input logic [7:0] v, output int n);
        write_reg(v);
        n = 1;
        while (!tick && n < 2000) begin
            step();
            n++;
        end
    endtask

    initial begin
        int n;
        idle(3);
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk(rd_data == 8'h00, "R1", "rd_data after reset", rd_data, 0);
        chk(!cfg_done && !tick, "R1", "flag/tick after reset", {cfg_done, tick}, 0);
        // R5: idle before any write
        tick_count = 0;
        idle(40);
        chk(tick_count == 0, "R5", "ticks before write", tick_count, 0);
        // R3: write with bit 7 clear still sets the flag; ratio 1
        write_reg(8'h00);
        chk(rd_data[7] == 1'b1, "R3", "flag after bit7=0 write", rd_data[7], 1);
        tick_count = 0;
        idle(10);
        chk(tick_count == 10, "R6", "ratio 1 ticks in 10", tick_count, 10);
        // R3/R8: bit 7 set in data, div 5 -> ratio 6
        first_tick_after(8'h85, n);
        chk(rd_data == 8'h85, "R3", "readback 0x85", rd_data, 8'h85);
        chk(n == 6, "R8", "first tick ratio 6", n, 6);
        idle(30);
        // R4: readback
        write_reg(8'h03);
        chk(rd_data == 8'h83, "R4", "readback after 0x03", rd_data, 8'h83);
        idle(20);
        // R7: prescaler on, ratio 16
        first_tick_after(8'h41, n);
        chk(n == 16, "R7", "first tick ratio 16", n, 16);
        idle(60);
        // R7: maximum ratio 512
        write_reg(8'h7F);
        tick_count = 0;
        idle(1100);
        chk(tick_count == 2, "R7", "ticks in 1100 at ratio 512", tick_count, 2);
        // R8: restart mid-count
        write_reg(8'h02);
        idle(1);
        first_tick_after(8'h02, n);
        chk(n == 3, "R8", "first tick after restart", n, 3);
        // R9: one pulse per 3 cycles
        tick_count = 0;
        idle(30);
        chk(tick_count == 10, "R9", "ticks in 30 at ratio 3", tick_count, 10);
        // R1: reset again clears the flag
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk(rd_data == 8'h00 && !cfg_done, "R1", "state after second reset", rd_data, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule